// File: doc/BRIEF.md
# Configurable Registered Command Buffer with Select Gating

This block is a clocked register bank on the command and address path of a memory module. Every input is captured on the rising clock edge and driven out one edge later. Two static configuration inputs pick how the bank is laid out. In wide mode, 25 inputs each feed one registered output. In dual mode, 14 captured bits each drive two output copies. A layout pin chooses which 14 input positions feed the bits in dual mode.

Two active-low select inputs control the data outputs. While both are high at a clock edge, the data outputs and the registered select copy keep their values. If either select is low, the outputs load normally. The clock-enable and termination-control inputs are registered on every edge, whatever the selects are. An active-low reset clears every register and drives all outputs low at once, with no clock needed. Reset is released in step with the clock, so capture resumes only on the third rising edge after reset goes high.

Top module: `crb_cmd_buffer`

## Requirements
- R1: With cfg_dual = 0 (wide mode), each rising edge that loads the bank sets q_prim[i] to data_in[i] for i = 0..24, and sets q_copy to all zeros.
- R2: With cfg_dual = 1 and cfg_alt = 0 (layout A), captured bit j for j = 0..13 is data_in[j]. It is driven on both q_prim[j] and q_copy[j], and q_prim[24:14] is zero.
- R3: With cfg_dual = 1 and cfg_alt = 1 (layout B), captured bit j for j = 0..13 is data_in[j+11]. It is driven on both q_prim[j] and q_copy[j], and q_prim[24:14] is zero.
- R4: While rst_n is low, every output is zero. This takes effect within the same time step that rst_n falls, needs no clock edge, and applies whatever the select inputs are.
- R5: After rst_n rises, all outputs stay zero through the first two rising edges. The third rising edge is the first one that captures inputs.
- R6: A rising edge at which sel_dram_n and sel_reg_n are both high leaves q_prim, q_copy and cs_q unchanged. If either select is low, the edge loads them.
- R7: cke_q and odt_q take cke_in and odt_in on every rising edge after reset has been released, whatever the select inputs are.
- R8: cs_q is the registered sel_dram_n and is gated like the data outputs. With sel_reg_n held low, it follows sel_dram_n one edge later, as an ordinary data bit does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dual | input | 1 | 0: 25-bit single-fanout mode, 1: 14-bit dual-fanout mode |
| cfg_alt | input | 1 | Dual-mode layout select, 0: layout A, 1: layout B |
| sel_dram_n | input | 1 | Active-low select, also registered onto cs_q |
| sel_reg_n | input | 1 | Active-low select that enables output gating |
| cke_in | input | 1 | Clock-enable control input |
| odt_in | input | 1 | Termination control input |
| data_in | input | 25 | Command and address inputs |
| q_prim | output | 25 | Primary registered outputs |
| q_copy | output | 14 | Second copy of the captured bits in dual mode |
| cs_q | output | 1 | Registered select |
| cke_q | output | 1 | Registered clock-enable |
| odt_q | output | 1 | Registered termination control |

## Verification
Data, select, clock-enable and termination outputs are all due one rising edge after their inputs. The bench drives inputs on the falling edge and compares every output at the next falling edge against a model that updates on the rising edge between the two. Reset is different. Its effect is due in the same time step, so the bench asserts reset partway through a low phase and checks one nanosecond later, before any edge. Release is counted in the model, so the outputs must stay zero through two edges and must capture on the third.

// File: rtl/crb_pkg.sv
package crb_pkg;

  typedef enum logic [1:0] {
    LAYOUT_WIDE   = 2'd0,
    LAYOUT_DUAL_A = 2'd1,
    LAYOUT_DUAL_B = 2'd2
  } layout_e;

  function automatic layout_e pick_layout(input logic dual, input logic alt);
    if (!dual)    return LAYOUT_WIDE;
    else if (alt) return LAYOUT_DUAL_B;
    else          return LAYOUT_DUAL_A;
  endfunction

endpackage

// File: rtl/crb_rst_sync.sv
module crb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic core_rst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign core_rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/crb_lane_select.sv
module crb_lane_select
  import crb_pkg::*;
#(
  parameter int WIDE   = 25,
  parameter int NARROW = 14
) (
  input  layout_e           layout,
  input  logic [WIDE-1:0]   data_in,
  output logic [WIDE-1:0]   next_prim,
  output logic [NARROW-1:0] next_copy
);
  localparam int OFFS = WIDE - NARROW;

  logic [NARROW-1:0] dual_bits;
  logic              dual_mode;

  assign dual_mode = (layout != LAYOUT_WIDE);

  for (genvar j = 0; j < NARROW; j++) begin : g_dual
    assign dual_bits[j] = (layout == LAYOUT_DUAL_B) ? data_in[j+OFFS] : data_in[j];
    assign next_copy[j] = dual_mode ? dual_bits[j] : 1'b0;
  end

  for (genvar i = 0; i < WIDE; i++) begin : g_prim
    if (i < NARROW) begin : g_shared
      assign next_prim[i] = dual_mode ? dual_bits[i] : data_in[i];
    end else begin : g_wide_only
      assign next_prim[i] = dual_mode ? 1'b0 : data_in[i];
    end
  end
endmodule

// File: rtl/crb_hold_reg.sv
module crb_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/crb_cmd_buffer.sv
module crb_cmd_buffer
  import crb_pkg::*;
#(
  parameter int WIDE        = 25,
  parameter int NARROW      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dual,
  input  logic              cfg_alt,
  input  logic              sel_dram_n,
  input  logic              sel_reg_n,
  input  logic              cke_in,
  input  logic              odt_in,
  input  logic [WIDE-1:0]   data_in,
  output logic [WIDE-1:0]   q_prim,
  output logic [NARROW-1:0] q_copy,
  output logic              cs_q,
  output logic              cke_q,
  output logic              odt_q
);
  localparam int GW = WIDE + NARROW + 1;

  logic              core_rst_n;
  logic              load_en;
  layout_e           layout;
  logic [WIDE-1:0]   next_prim;
  logic [NARROW-1:0] next_copy;
  logic [GW-1:0]     gated_d;
  logic [GW-1:0]     gated_q;
  logic [1:0]        ctl_q;

  crb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_rst_n (core_rst_n)
  );

  assign layout  = pick_layout(cfg_dual, cfg_alt);
  assign load_en = ~(sel_dram_n & sel_reg_n);

  crb_lane_select #(.WIDE(WIDE), .NARROW(NARROW)) u_lane_select (
    .layout    (layout),
    .data_in   (data_in),
    .next_prim (next_prim),
    .next_copy (next_copy)
  );

  assign gated_d = {sel_dram_n, next_copy, next_prim};

  crb_hold_reg #(.W(GW)) u_gated_bank (
    .clk   (clk),
    .rst_n (core_rst_n),
    .en    (load_en),
    .d     (gated_d),
    .q     (gated_q)
  );

  crb_hold_reg #(.W(2)) u_ctl_bank (
    .clk   (clk),
    .rst_n (core_rst_n),
    .en    (1'b1),
    .d     ({odt_in, cke_in}),
    .q     (ctl_q)
  );

  assign q_prim = gated_q[WIDE-1:0];
  assign q_copy = gated_q[WIDE+NARROW-1:WIDE];
  assign cs_q   = gated_q[GW-1];
  assign cke_q  = ctl_q[0];
  assign odt_q  = ctl_q[1];

  // R4: outputs low while reset is held
  a_r4_reset_low: assert property (@(posedge clk)
    !rst_n |-> (q_prim == '0 && q_copy == '0 && !cs_q && !cke_q && !odt_q));

  // R6: both selects high hold the gated outputs
  a_r6_hold: assert property (@(posedge clk) disable iff (!core_rst_n)
    (sel_dram_n && sel_reg_n) |=> ($stable(q_prim) && $stable(q_copy) && $stable(cs_q)));

  // R7: control outputs follow inputs one edge later
  a_r7_ctl_follow: assert property (@(posedge clk) disable iff (!rst_n)
    $past(core_rst_n) |-> (cke_q == $past(cke_in) && odt_q == $past(odt_in)));

  // R1: wide-mode load leaves copy bus low
  a_r1_copy_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(core_rst_n) && $past(load_en) && !$past(cfg_dual)) |-> q_copy == '0);

  // R2/R3: dual-mode load drives identical copies
  a_r2_copies_match: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(core_rst_n) && $past(load_en) && $past(cfg_dual)) |->
      (q_copy == q_prim[NARROW-1:0] && q_prim[WIDE-1:NARROW] == '0));
endmodule

// File: tb/crb_cmd_buffer_bench.sv
module crb_cmd_buffer_bench;
  localparam int WIDE = 25;
  localparam int NARROW = 14;
  localparam int OFFS = WIDE - NARROW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_dual = 1'b0, cfg_alt = 1'b0;
  logic sel_dram_n = 1'b0, sel_reg_n = 1'b0;
  logic cke_in = 1'b0, odt_in = 1'b0;
  logic [WIDE-1:0] data_in = '0;
  logic [WIDE-1:0] q_prim;
  logic [NARROW-1:0] q_copy;
  logic cs_q, cke_q, odt_q;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  crb_cmd_buffer u_crb_cmd_buffer (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_alt(cfg_alt),
    .sel_dram_n(sel_dram_n), .sel_reg_n(sel_reg_n), .cke_in(cke_in), .odt_in(odt_in),
    .data_in(data_in), .q_prim(q_prim), .q_copy(q_copy), .cs_q(cs_q),
    .cke_q(cke_q), .odt_q(odt_q)
  );

  function automatic logic [WIDE-1:0] f_prim(input logic dual, input logic alt,
                                             input logic [WIDE-1:0] d);
    if (!dual) return d;
    return {{OFFS{1'b0}}, (alt ? d[WIDE-1:OFFS] : d[NARROW-1:0])};
  endfunction

  function automatic logic [NARROW-1:0] f_copy(input logic dual, input logic alt,
                                               input logic [WIDE-1:0] d);
    if (!dual) return '0;
    return alt ? d[WIDE-1:OFFS] : d[NARROW-1:0];
  endfunction

  // model
  logic [WIDE-1:0] e_prim = '0;
  logic [NARROW-1:0] e_copy = '0;
  logic e_cs = 1'b0, e_cke = 1'b0, e_odt = 1'b0;
  int m_cnt = 0;
  string m_tag = "R4";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; e_prim <= '0; e_copy <= '0; e_cs <= 1'b0; e_cke <= 1'b0; e_odt <= 1'b0;
      m_tag <= "R4";
    end else if (m_cnt < 2) begin
      m_cnt <= m_cnt + 1;
      m_tag <= "R5";
    end else begin
      e_cke <= cke_in;
      e_odt <= odt_in;
      if (!(sel_dram_n && sel_reg_n)) begin
        e_prim <= f_prim(cfg_dual, cfg_alt, data_in);
        e_copy <= f_copy(cfg_dual, cfg_alt, data_in);
        e_cs   <= sel_dram_n;
        m_tag  <= !cfg_dual ? "R1" : (cfg_alt ? "R3" : "R2");
      end else begin
        m_tag <= "R6";
      end
    end
  end

  task automatic check_vec(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    check_vec(tag, {25'b0, q_copy, q_prim}, {25'b0, e_copy, e_prim});
    check_vec(tag == "R6" ? "R6" : "R8", {63'b0, cs_q}, {63'b0, e_cs});
    check_vec("R7", {62'b0, odt_q, cke_q}, {62'b0, e_odt, e_cke});
  endtask

  task automatic check_zero(input string tag);
    check_vec(tag, {22'b0, odt_q, cke_q, cs_q, q_copy, q_prim}, 64'd0);
  endtask

  task automatic drive(input logic dual, input logic alt, input logic dn, input logic rn,
                       input logic [WIDE-1:0] d);
    cfg_dual = dual; cfg_alt = alt; sel_dram_n = dn; sel_reg_n = rn; data_in = d;
  endtask

  task automatic step_check();
    @(negedge clk);
    check_all(m_tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    // R4: reset state
    repeat (3) @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 25'h1FFFFFF);
    cke_in = 1'b1; odt_in = 1'b1;
    @(negedge clk);
    check_zero("R4");
    // R5: release timing, inputs nonzero
    rst_n = 1'b1;
    @(negedge clk); check_zero("R5");
    @(negedge clk); check_zero("R5");
    @(negedge clk);
    check_vec("R5", {39'b0, q_prim}, {39'b0, 25'h1FFFFFF});
    check_vec("R7", {62'b0, odt_q, cke_q}, 64'd3);
    // R1: wide mode
    drive(1'b0, 1'b0, 1'b1, 1'b0, 25'h0A5C3F1);
    @(negedge clk);
    check_vec("R1", {25'b0, q_copy, q_prim}, {25'b0, 14'b0, 25'h0A5C3F1});
    check_vec("R8", {63'b0, cs_q}, 64'd1);
    // R2: layout A
    drive(1'b1, 1'b0, 1'b0, 1'b0, 25'h1F03A5C);
    @(negedge clk);
    check_vec("R2", {25'b0, q_copy, q_prim}, {25'b0, 14'h3A5C, 11'b0, 14'h3A5C});
    check_vec("R8", {63'b0, cs_q}, 64'd0);
    // R3: layout B, bit j = data_in[j+11]
    drive(1'b1, 1'b1, 1'b0, 1'b1, 25'h1555800);
    @(negedge clk);
    check_vec("R3", {25'b0, q_copy, q_prim}, {25'b0, 14'h2AAB, 11'b0, 14'h2AAB});
    // R6: both selects high hold, controls still move
    drive(1'b0, 1'b0, 1'b1, 1'b1, 25'h0123456);
    cke_in = 1'b0; odt_in = 1'b1;
    @(negedge clk);
    check_vec("R6", {25'b0, q_copy, q_prim}, {25'b0, 14'h2AAB, 11'b0, 14'h2AAB});
    check_vec("R6", {63'b0, cs_q}, 64'd0);
    check_vec("R7", {62'b0, odt_q, cke_q}, 64'd2);
    // R4: reset mid low phase with selects high, no edge
    #2 rst_n = 1'b0;
    #1 check_zero("R4");
    @(negedge clk); check_all(m_tag);
    rst_n = 1'b1;
    // random phase
    for (int k = 0; k < 3000; k++) begin
      step_check();
      drive($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(0, 1), $urandom & 25'h1FFFFFF);
      cke_in = $urandom_range(0, 1); odt_in = $urandom_range(0, 1);
      if ($urandom_range(0, 63) == 0) begin
        #($urandom_range(1, 3)) rst_n = 1'b0;
        #1 check_zero("R4");
        repeat ($urandom_range(1, 3)) step_check();
        rst_n = 1'b1;
      end
    end
    step_check();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule